// File: doc/BRIEF.md
# Internal Data Memory Decoder

This block holds the 256-byte on-chip scratch RAM of an 8-bit controller core and decides, for every access, where the access goes. The core presents an 8-bit address, an access mode, a flag for working-register accesses, the two register-bank select bits and read/write strobes. The block then steers the access to the lower RAM half, to the upper RAM half, or out through a special-function-register (SFR) port to logic that lives elsewhere.

The upper address half (80h–FFh) is two separate spaces. Direct byte accesses there go to the SFR port. Indirect accesses, including stack traffic, reach the upper RAM. Working-register accesses are relocated into one of four eight-byte banks. Bit accesses either read-modify-write one bit of a byte in the 20h–2Fh window within one clock, or are forwarded to the SFR port. The block knows which SFR addresses exist. Accesses to any other SFR address are stopped here and flagged.

Top module: `idata_decoder`

## Requirements
- R1: mode_i encodes 00 direct, 01 indirect, 10 bit, 11 no access. Indirect byte accesses at any address, and direct byte accesses below 80h, read or write the RAM byte at addr_i.
- R2: Direct byte accesses at 80h–FFh drive the SFR port (sfr_addr_o = addr_i, sfr_rd_o or sfr_wr_o, sfr_bit_o low) and leave RAM unchanged. Indirect accesses never raise an SFR strobe.
- R3: With rn_i high in direct or indirect mode, the byte accessed is bank_i*8 + addr_i[2:0].
- R4: A bit access with addr_i below 80h selects byte 20h + addr_i[6:3], bit addr_i[2:0]. A read returns the bit in rdata_o[0] with rdata_o[7:1] zero. A write changes only that bit, in one clock.
- R5: A bit access with addr_i at 80h or above is forwarded with sfr_bit_o high, sfr_addr_o = addr_i and sfr_wdata_o = {7'b0, bit_i}. A read returns sfr_rdata_i[0] in rdata_o[0].
- R6: An SFR byte address a is implemented when bit a-80h of SFR_IMPL is set. A bit access uses the byte address {addr_i[7:3],3'b000}. On an unimplemented address, sfr_unimpl_o is high, no SFR strobe rises, and a read returns UNIMPL_FILL.
- R7: Read data is valid in the same cycle as rd_i. A write takes effect at the next rising clock edge. A read in the cycle of a write to the same byte returns the old content.
- R8: When rd_i is low, or mode_i is 11, rdata_o is zero. Mode 11 raises no strobe and writes nothing.
- R9: While rst_ni is low, no SFR strobe rises and no RAM write happens. Reset does not clear the RAM.
- R10: When no SFR access is active, sfr_addr_o, sfr_wdata_o, sfr_bit_o and sfr_unimpl_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; blocks all accesses while low |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| mode_i | input | 2 | Access mode: 00 direct, 01 indirect, 10 bit, 11 none |
| rn_i | input | 1 | Working-register access; addr_i[2:0] is the register index |
| bank_i | input | 2 | Register-bank select |
| addr_i | input | 8 | Byte address or bit address |
| wdata_i | input | 8 | Byte write data |
| bit_i | input | 1 | Bit write value |
| rdata_o | output | 8 | Read data (bit reads in bit 0) |
| sfr_rd_o | output | 1 | SFR read strobe |
| sfr_wr_o | output | 1 | SFR write strobe |
| sfr_bit_o | output | 1 | SFR access is a bit access |
| sfr_addr_o | output | 8 | SFR byte or bit address |
| sfr_wdata_o | output | 8 | SFR write data |
| sfr_rdata_i | input | 8 | SFR read data returned by external logic |
| sfr_unimpl_o | output | 1 | Access targets an unimplemented SFR address |

## Verification
The bench builds the block with UNIMPL_FILL = A5h and an SFR map in which an address is implemented exactly when it is not divisible by three. This gives a dense mix of present and absent registers, including bit-addressable bases on both sides (80h present, 90h absent). With the non-default fill, a forwarded read and a blocked read cannot be confused. Because the whole RAM is pre-filled first, every later byte read, bit read, bank-relocated access and read-modify-write can be checked against known contents, including the upper bytes that direct accesses must not touch.

// File: rtl/idata_pkg.sv
package idata_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT   = 2'b00,
    MODE_INDIRECT = 2'b01,
    MODE_BIT      = 2'b10,
    MODE_NONE     = 2'b11
  } acc_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_RAM  = 2'b01,
    TGT_SFR  = 2'b10
  } tgt_e;

  function automatic logic [127:0] mark_range(logic [127:0] m, int lo, int hi);
    logic [127:0] r;
    r = m;
    for (int a = lo; a <= hi; a++) r[7'(a - 128)] = 1'b1;
    return r;
  endfunction

  // Default map of present SFR byte addresses (bit n = address 80h+n)
  function automatic logic [127:0] sfr_std_map();
    logic [127:0] m;
    m = '0;
    m = mark_range(m, 'hF8, 'hFD);
    m = mark_range(m, 'hE8, 'hED);
    m = mark_range(m, 'hD8, 'hDE);
    m = mark_range(m, 'hC8, 'hCD);
    m = mark_range(m, 'h88, 'h8D);
    m = mark_range(m, 'h80, 'h83);
    m = mark_range(m, 'hA8, 'hA9);
    m = mark_range(m, 'hB8, 'hB9);
    m = mark_range(m, 'h98, 'h99);
    m = mark_range(m, 'hB0, 'hB0);
    m = mark_range(m, 'hB7, 'hB7);
    m = mark_range(m, 'h87, 'h87);
    m = mark_range(m, 'h90, 'h90);
    m = mark_range(m, 'hA0, 'hA0);
    m = mark_range(m, 'hD0, 'hD0);
    m = mark_range(m, 'hE0, 'hE0);
    m = mark_range(m, 'hF0, 'hF0);
    return m;
  endfunction

endpackage

// File: rtl/idata_addr_map.sv
module idata_addr_map
  import idata_pkg::*;
#(
  parameter int          AW       = 8,
  parameter logic [7:0]  BIT_BASE = 8'h20
) (
  input  acc_mode_e     mode_i,
  input  logic          rn_i,
  input  logic [1:0]    bank_i,
  input  logic [AW-1:0] addr_i,
  output tgt_e          tgt_o,
  output logic [AW-1:0] phys_o,
  output logic          bit_o,
  output logic [2:0]    bit_sel_o
);

  logic [AW-1:0] bank_addr;
  logic [AW-1:0] bitbyte_addr;

  assign bank_addr    = AW'({bank_i, addr_i[2:0]});
  assign bitbyte_addr = AW'(BIT_BASE) + AW'(addr_i[6:3]);
  assign bit_sel_o    = addr_i[2:0];

  always_comb begin
    tgt_o  = TGT_NONE;
    phys_o = addr_i;
    bit_o  = 1'b0;
    unique case (mode_i)
      MODE_DIRECT: begin
        if (rn_i) begin
          tgt_o  = TGT_RAM;
          phys_o = bank_addr;
        end else if (addr_i[AW-1]) begin
          tgt_o  = TGT_SFR;
        end else begin
          tgt_o  = TGT_RAM;
        end
      end
      MODE_INDIRECT: begin
        tgt_o = TGT_RAM;
        if (rn_i) phys_o = bank_addr;
      end
      MODE_BIT: begin
        bit_o = 1'b1;
        if (addr_i[AW-1]) begin
          tgt_o = TGT_SFR;
        end else begin
          tgt_o  = TGT_RAM;
          phys_o = bitbyte_addr;
        end
      end
      default: tgt_o = TGT_NONE;
    endcase
  end

endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int BW    = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     addr_i,
  input  logic              we_i,
  input  logic              bit_i,
  input  logic [BW-1:0]     bit_sel_i,
  input  logic              bit_val_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  // No reset: contents survive reset and start undefined
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] next_word;

  assign rdata_o = mem[addr_i];

  always_comb begin
    next_word = wdata_i;
    if (bit_i) begin
      next_word            = rdata_o;
      next_word[bit_sel_i] = bit_val_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= next_word;
  end

endmodule

// File: rtl/idata_sfr_gate.sv
module idata_sfr_gate #(
  parameter int           AW       = 8,
  parameter int           DATA_W   = 8,
  parameter logic [127:0] SFR_IMPL = '1
) (
  input  logic              sel_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              bit_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_val_i,
  output logic              present_o,
  output logic              sfr_rd_o,
  output logic              sfr_wr_o,
  output logic              sfr_bit_o,
  output logic [AW-1:0]     sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  output logic              unimpl_o
);

  logic [AW-2:0] map_idx;

  // Bit accesses are qualified by the byte that holds the bit
  assign map_idx   = bit_i ? {addr_i[AW-2:3], 3'b000} : addr_i[AW-2:0];
  assign present_o = SFR_IMPL[map_idx];

  assign sfr_rd_o    = sel_i & present_o & rd_i;
  assign sfr_wr_o    = sel_i & present_o & wr_i;
  assign sfr_bit_o   = sel_i & bit_i;
  assign unimpl_o    = sel_i & ~present_o;
  assign sfr_addr_o  = sel_i ? addr_i : '0;
  assign sfr_wdata_o = !sel_i ? '0
                     : bit_i ? {{(DATA_W-1){1'b0}}, bit_val_i}
                     : wdata_i;

endmodule

// File: rtl/idata_decoder.sv
module idata_decoder
  import idata_pkg::*;
#(
  parameter int           DEPTH       = 256,
  parameter int           DATA_W      = 8,
  parameter logic [7:0]   BIT_BASE    = 8'h20,
  parameter logic [7:0]   UNIMPL_FILL = 8'hFF,
  parameter logic [127:0] SFR_IMPL    = sfr_std_map()
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic              rn_i,
  input  logic [1:0]        bank_i,
  input  logic [7:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sfr_rd_o,
  output logic              sfr_wr_o,
  output logic              sfr_bit_o,
  output logic [7:0]        sfr_addr_o,
  output logic [DATA_W-1:0] sfr_wdata_o,
  input  logic [DATA_W-1:0] sfr_rdata_i,
  output logic              sfr_unimpl_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(DATA_W);

  tgt_e              tgt;
  logic [AW-1:0]     phys;
  logic              is_bit;
  logic [2:0]        bit_sel;
  logic              active;
  logic              ram_we;
  logic              sfr_sel;
  logic              sfr_present;
  logic [DATA_W-1:0] ram_rdata;

  assign active  = rst_ni & (rd_i | wr_i);
  assign ram_we  = rst_ni & wr_i & (tgt == TGT_RAM);
  assign sfr_sel = active & (tgt == TGT_SFR);

  idata_addr_map #(
    .AW       (AW),
    .BIT_BASE (BIT_BASE)
  ) u_map (
    .mode_i    (acc_mode_e'(mode_i)),
    .rn_i      (rn_i),
    .bank_i    (bank_i),
    .addr_i    (AW'(addr_i)),
    .tgt_o     (tgt),
    .phys_o    (phys),
    .bit_o     (is_bit),
    .bit_sel_o (bit_sel)
  );

  idata_ram #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
  ) u_ram (
    .clk_i     (clk_i),
    .addr_i    (phys),
    .we_i      (ram_we),
    .bit_i     (is_bit),
    .bit_sel_i (BW'(bit_sel)),
    .bit_val_i (bit_i),
    .wdata_i   (wdata_i),
    .rdata_o   (ram_rdata)
  );

  idata_sfr_gate #(
    .AW       (8),
    .DATA_W   (DATA_W),
    .SFR_IMPL (SFR_IMPL)
  ) u_sfr (
    .sel_i       (sfr_sel),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .bit_i       (is_bit),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .bit_val_i   (bit_i),
    .present_o   (sfr_present),
    .sfr_rd_o    (sfr_rd_o),
    .sfr_wr_o    (sfr_wr_o),
    .sfr_bit_o   (sfr_bit_o),
    .sfr_addr_o  (sfr_addr_o),
    .sfr_wdata_o (sfr_wdata_o),
    .unimpl_o    (sfr_unimpl_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rst_ni && rd_i) begin
      unique case (tgt)
        TGT_RAM: rdata_o = is_bit ? DATA_W'(ram_rdata[BW'(bit_sel)]) : ram_rdata;
        TGT_SFR: begin
          if (!sfr_present)  rdata_o = UNIMPL_FILL;
          else if (is_bit)   rdata_o = DATA_W'(sfr_rdata_i[0]);
          else               rdata_o = sfr_rdata_i;
        end
        default: rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/idata_decoder_chk.sv
module idata_decoder_chk #(
  parameter int         DATA_W      = 8,
  parameter logic [7:0] UNIMPL_FILL = 8'hFF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic              wr_i,
  input logic [1:0]        mode_i,
  input logic              rn_i,
  input logic [7:0]        addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              sfr_rd_o,
  input logic              sfr_wr_o,
  input logic              sfr_bit_o,
  input logic [7:0]        sfr_addr_o,
  input logic              sfr_unimpl_o
);

  AST_LOW_DIRECT_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && !addr_i[7]) |-> (!sfr_rd_o && !sfr_wr_o)); // R1

  AST_INDIRECT_NO_SFR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |-> (!sfr_rd_o && !sfr_wr_o && !sfr_unimpl_o)); // R2

  AST_BIT_READ_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && mode_i == 2'b10 && !sfr_unimpl_o) |-> (rdata_o[DATA_W-1:1] == '0)); // R4

  AST_UNIMPL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_unimpl_o |-> (!sfr_rd_o && !sfr_wr_o)); // R6

  AST_UNIMPL_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_unimpl_o && rd_i) |-> (rdata_o == UNIMPL_FILL)); // R6

  AST_WRITE_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(wr_i) && $past(mode_i) == 2'b01 && !$past(rn_i) &&
     rd_i && mode_i == 2'b01 && !rn_i && addr_i == $past(addr_i))
    |-> (rdata_o == $past(wdata_i))); // R7

  AST_NO_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i || mode_i == 2'b11) |-> (rdata_o == '0)); // R8

  AST_IDLE_PORT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> (sfr_addr_o == '0 && !sfr_bit_o && !sfr_unimpl_o)); // R10

endmodule

bind idata_decoder idata_decoder_chk #(
  .DATA_W      (DATA_W),
  .UNIMPL_FILL (UNIMPL_FILL)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_i         (rd_i),
  .wr_i         (wr_i),
  .mode_i       (mode_i),
  .rn_i         (rn_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .rdata_o      (rdata_o),
  .sfr_rd_o     (sfr_rd_o),
  .sfr_wr_o     (sfr_wr_o),
  .sfr_bit_o    (sfr_bit_o),
  .sfr_addr_o   (sfr_addr_o),
  .sfr_unimpl_o (sfr_unimpl_o)
);

// File: tb/idata_decoder_bench.sv
`timescale 1ns/1ps
module idata_decoder_bench;

  localparam logic [7:0] FILL = 8'hA5;

  function automatic logic [127:0] tb_map();
    logic [127:0] m;
    for (int i = 0; i < 128; i++) m[i] = ((128 + i) % 3) != 0;
    return m;
  endfunction

  localparam logic [127:0] MAP = tb_map();

  logic       clk_i = 1'b0;
  logic       rst_ni, rd_i, wr_i, rn_i, bit_i;
  logic [1:0] mode_i, bank_i;
  logic [7:0] addr_i, wdata_i, rdata_o, sfr_addr_o, sfr_wdata_o, sfr_rdata_i;
  logic       sfr_rd_o, sfr_wr_o, sfr_bit_o, sfr_unimpl_o;

  int  ref_mem [256];
  int  vecs  = 0;
  int  fails = 0;
  bit  done  = 0;

  always #2.5 clk_i = ~clk_i;

  // External SFR stand-in: data depends on the presented address
  assign sfr_rdata_i = sfr_addr_o ^ 8'h3C;

  idata_decoder #(
    .UNIMPL_FILL (FILL),
    .SFR_IMPL    (MAP)
  ) u_idata_decoder (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_i         (rd_i),
    .wr_i         (wr_i),
    .mode_i       (mode_i),
    .rn_i         (rn_i),
    .bank_i       (bank_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .bit_i        (bit_i),
    .rdata_o      (rdata_o),
    .sfr_rd_o     (sfr_rd_o),
    .sfr_wr_o     (sfr_wr_o),
    .sfr_bit_o    (sfr_bit_o),
    .sfr_addr_o   (sfr_addr_o),
    .sfr_wdata_o  (sfr_wdata_o),
    .sfr_rdata_i  (sfr_rdata_i),
    .sfr_unimpl_o (sfr_unimpl_o)
  );

  function automatic bit present(int a);
    return (a % 3) != 0;
  endfunction

  task automatic apply(bit rst, bit rd, bit wr, int mode, bit rn, int bank,
                       int addr, int wd, bit bv);
    bit ram = 0, sfr = 0, bm = 0, on, ok;
    int idx = 0, bp = 0;
    int e_rd, e_addr, e_wd;
    bit e_srd, e_swr, e_sbit, e_un;
    string tag;
    @(negedge clk_i);
    rst_ni = rst; rd_i = rd; wr_i = wr; mode_i = 2'(mode); rn_i = rn;
    bank_i = 2'(bank); addr_i = 8'(addr); wdata_i = 8'(wd); bit_i = bv;
    #1;
    if (mode == 2) begin
      bm = 1;
      if (addr < 128) begin ram = 1; idx = 32 + addr / 8; bp = addr % 8; end
      else sfr = 1;
    end else if (mode < 2) begin
      if (rn) begin ram = 1; idx = bank * 8 + addr % 8; end
      else if (mode == 0 && addr >= 128) sfr = 1;
      else begin ram = 1; idx = addr; end
    end
    on = rst && (rd || wr);
    ok = present(bm ? addr - addr % 8 : addr);
    e_un   = on && sfr && !ok;
    e_srd  = rst && rd && sfr && ok;
    e_swr  = rst && wr && sfr && ok;
    e_sbit = on && sfr && bm;
    e_addr = (on && sfr) ? addr : 0;
    e_wd   = (on && sfr) ? (bm ? int'(bv) : wd) : 0;
    if (!(rst && rd))  e_rd = 0;
    else if (ram)      e_rd = bm ? (ref_mem[idx] >> bp) & 1 : ref_mem[idx];
    else if (sfr)      e_rd = !ok ? int'(FILL) : bm ? ((addr ^ 'h3C) & 1) : (addr ^ 'h3C);
    else               e_rd = 0;
    if (!rst)                        tag = "R9";
    else if (!(rd || wr) || mode==3) tag = "R8";
    else if (sfr && !ok)             tag = "R6";
    else if (sfr && bm)              tag = "R5";
    else if (sfr)                    tag = "R2";
    else if (bm)                     tag = "R4";
    else if (rn)                     tag = "R3";
    else if (rd && wr)               tag = "R7";
    else                             tag = "R1";
    if (!on) tag = {tag, "/R10"};
    vecs++;
    if (rdata_o !== 8'(e_rd) || sfr_rd_o !== e_srd || sfr_wr_o !== e_swr ||
        sfr_bit_o !== e_sbit || sfr_unimpl_o !== e_un ||
        sfr_addr_o !== 8'(e_addr) || sfr_wdata_o !== 8'(e_wd)) begin
      fails++;
      $display("FAIL %s: got rd=%h srd=%b swr=%b sbit=%b un=%b sa=%h swd=%h exp rd=%h srd=%b swr=%b sbit=%b un=%b sa=%h swd=%h",
               tag, rdata_o, sfr_rd_o, sfr_wr_o, sfr_bit_o, sfr_unimpl_o, sfr_addr_o,
               sfr_wdata_o, 8'(e_rd), e_srd, e_swr, e_sbit, e_un, 8'(e_addr), 8'(e_wd));
    end
    if (rst && wr && ram) begin
      if (bm) ref_mem[idx] = bv ? (ref_mem[idx] | (1 << bp)) : (ref_mem[idx] & ~(1 << bp));
      else    ref_mem[idx] = wd & 'hFF;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      finish_run();
    end
  end

  initial begin
    rst_ni = 0; rd_i = 0; wr_i = 0; mode_i = 0; rn_i = 0; bank_i = 0;
    addr_i = 0; wdata_i = 0; bit_i = 0;
    // R9 / R10: reset state, strobes held off
    apply(0, 0, 0, 0, 0, 0, 8'h00, 0, 0);
    apply(0, 1, 1, 0, 0, 0, 8'h85, 8'h11, 0);
    apply(0, 1, 1, 2, 0, 0, 8'h88, 0, 1);
    // R1: pre-fill all of RAM through indirect writes
    for (int i = 0; i < 256; i++) apply(1, 0, 1, 1, 0, 0, i, (i * 7 + 3) & 'hFF, 0);
    apply(1, 1, 0, 0, 0, 0, 8'h45, 0, 0);           // R1 direct low
    apply(1, 1, 0, 1, 0, 0, 8'hF0, 0, 0);           // R1 indirect upper
    // R3: bank relocation
    apply(1, 0, 1, 0, 1, 2, 8'h03, 8'hC3, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h13, 0, 0);
    apply(1, 1, 0, 1, 1, 3, 8'hFF, 0, 0);           // R3 index from low bits only
    apply(1, 1, 0, 0, 1, 0, 8'h05, 0, 0);           // R3 bank 0
    // R4: bit read-modify-write in the bit window
    apply(1, 0, 1, 2, 0, 0, 8'h7F, 0, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h2F, 0, 0);
    apply(1, 0, 1, 2, 0, 0, 8'h00, 0, 1);
    apply(1, 1, 0, 2, 0, 0, 8'h00, 0, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h20, 0, 0);
    // R2: direct upper goes to SFR, upper RAM untouched
    apply(1, 0, 1, 0, 0, 0, 8'h80, 8'h55, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h80, 0, 0);
    apply(1, 1, 0, 0, 0, 0, 8'hB0, 0, 0);
    // R5: forwarded bit accesses
    apply(1, 1, 0, 2, 0, 0, 8'h83, 0, 0);
    apply(1, 0, 1, 2, 0, 0, 8'h8C, 0, 1);
    // R6: unimplemented addresses (81h, bit in 90h byte)
    apply(1, 0, 1, 0, 0, 0, 8'h81, 8'h77, 0);
    apply(1, 1, 0, 0, 0, 0, 8'h81, 0, 0);
    apply(1, 1, 0, 2, 0, 0, 8'h93, 0, 0);
    // R7: read and write of the same byte in one cycle
    apply(1, 1, 1, 1, 0, 0, 8'h60, 8'h9E, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h60, 0, 0);
    // R8: reserved mode, no read
    apply(1, 1, 1, 3, 0, 0, 8'h10, 8'h00, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h10, 0, 0);
    apply(1, 0, 0, 1, 0, 0, 8'h10, 0, 0);
    // R9: writes blocked in reset, contents kept across reset
    apply(0, 0, 1, 1, 0, 0, 8'h60, 8'h00, 0);
    apply(1, 1, 0, 1, 0, 0, 8'h60, 0, 0);
    apply(1, 1, 0, 1, 0, 0, 8'hC7, 0, 0);
    // Mixed traffic, all requirements
    for (int n = 0; n < 4000; n++)
      apply(($urandom % 50) != 0, $urandom % 2, ($urandom % 3) == 0, $urandom % 4,
            ($urandom % 4) == 0, $urandom % 4, $urandom % 256, $urandom % 256,
            $urandom % 2);
    finish_run();
  end

endmodule